// File: doc/BRIEF.md
# Page-Mode DRAM Strobe Decoder

This block is the control logic that sits on the memory side of a page-mode DRAM. It is written as a synthesizable model for tests. A fast clock samples the active-low row strobe, the two per-byte column strobes, write enable and output enable. The block finds the edges of these signals and latches the row and column addresses. It classifies each access as a read, an early write, a late write or a refresh, and it steps an internal row counter on every refresh.

Storage is a small register array indexed by the low bits of the latched row and column. The two column strobes are merged into one internal strobe, which goes active on the first byte strobe to fall and inactive on the last to rise. Data drive and data capture stay per byte. The output enables follow the usual strobe and output-enable ordering rules. Read data stays held across a refresh that is hidden under a held column strobe.

Top module: `dram_strobe_dec`

## Requirements
- R1: During reset (rst_ni low), and right after it, `cyc_o` is 0 (idle), `dq_oe_o` is 0 and `ref_row_o` is 0.
- R2: A row strobe fall while both column strobes are high latches `addr_i` as the row and sets `cyc_o` to 1 (row open). A row strobe sampled high gives `cyc_o` = 0 (idle) from the following cycle on.
- R3: The internal column strobe goes active when the first byte strobe falls. The column is latched from `addr_i` at that instant, and a later fall of the other byte strobe does not re-latch it. The column cycle ends (`cyc_o` back to 1) only when both byte strobes are high.
- R4: A column strobe fall with write enable high is a read (`cyc_o` = 2). The stored word at {row, column} is captured. The low strobe drives `dq_o[7:0]` and the high strobe drives `dq_o[15:8]`, each while that strobe is low and output enable is low. `dq_oe_o[0]` and `dq_oe_o[1]` flag the two lanes, and lanes that are not driven read 0.
- R5: Write enable low at the column strobe fall is an early write (`cyc_o` = 3). Both output enables stay 0 for the whole column cycle.
- R6: Write enable falling while the column strobe is low in a read gives a late write (`cyc_o` = 4). Outputs go off and stay off for the rest of the column cycle, even if output enable goes low.
- R7: Each byte lane writes `dq_i` for its own lane on the later of its strobe fall and the write enable fall. A lane whose strobe stays high keeps its stored byte.
- R8: A row strobe fall while either column strobe is low is a refresh (`cyc_o` = 5). `ref_row_o` advances by one, wrapping from 4095 to 0. The array is not changed, and `ref_row_o` changes at no other time.
- R9: A lane whose strobe is high has its output enable off, whatever output enable says. Output enable high turns both lanes off. Output enable going low again while the strobe is still low drives the previously read data again.
- R10: Read data stays driven while the column strobes stay low across a row strobe rise and a following refresh. It stops only when the column strobes go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| casl_n_i | input | 1 | Low-byte column strobe, active low |
| cash_n_i | input | 1 | High-byte column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | 2*LANE_W | Write data |
| dq_o | output | 2*LANE_W | Read data, zero on lanes not driven |
| dq_oe_o | output | 2 | Per-lane output drive enable |
| cyc_o | output | 3 | Cycle type: 0 idle, 1 row open, 2 read, 3 early write, 4 late write, 5 refresh |
| ref_row_o | output | ADDR_W | Next row the refresh counter will use |

## Verification
The bench uses the defaults: a 12-bit address, with 3 row bits and 3 column bits indexing the array. With these values two rows that share a column can be told apart, which shows that the row latch matters. The 12-bit counter is short enough for the bench to run 4096 refreshes and see it wrap. Byte-lane writes are shown by partial-lane stores over a known word. The single-lane read with the other strobe falling later shows the first-fall column latch.

// File: rtl/dram_sd_pkg.sv
package dram_sd_pkg;
  localparam int LANES = 2;

  typedef enum logic [2:0] {
    CYC_IDLE = 3'd0,
    CYC_ROW  = 3'd1,
    CYC_READ = 3'd2,
    CYC_EWR  = 3'd3,
    CYC_LWR  = 3'd4,
    CYC_REF  = 3'd5
  } cyc_e;
endpackage

// File: rtl/dram_sd_fsm.sv
module dram_sd_fsm
  import dram_sd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int AR_W   = 3,
  parameter int AC_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic              cas_n_i,   // merged: low while either byte strobe low
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cyc_e              cyc_o,
  output logic [AR_W-1:0]   row_o,
  output logic [AC_W-1:0]   col_o,
  output logic              access_o,
  output logic              rd_load_o,
  output logic              wr_seen_o,
  output logic [ADDR_W-1:0] ref_row_o
);
  cyc_e              state_q;
  logic              ras_q, cas_q, we_q, wr_seen_q;
  logic [AR_W-1:0]   row_q;
  logic [AC_W-1:0]   col_q;
  logic [ADDR_W-1:0] ref_q;
  logic              ras_fall, ras_rise, cas_fall, cas_rise, we_fall, access_q;

  always_comb begin
    ras_fall = ras_q & ~ras_n_i;
    ras_rise = ~ras_q & ras_n_i;
    cas_fall = cas_q & ~cas_n_i;
    cas_rise = ~cas_q & cas_n_i;
    we_fall  = we_q & ~we_n_i;
    access_q = (state_q == CYC_ROW) || (state_q == CYC_READ) ||
               (state_q == CYC_EWR) || (state_q == CYC_LWR);
  end

  // column taken from the pins on the same edge that latches it
  assign col_o     = (access_q && cas_fall) ? addr_i[AC_W-1:0] : col_q;
  assign row_o     = row_q;
  assign access_o  = access_q;
  assign rd_load_o = access_q & ~ras_rise & cas_fall & we_n_i;
  assign wr_seen_o = wr_seen_q;
  assign cyc_o     = state_q;
  assign ref_row_o = ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CYC_IDLE;
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      we_q      <= 1'b1;
      wr_seen_q <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      ref_q     <= '0;
    end else begin
      ras_q <= ras_n_i;
      cas_q <= cas_n_i;
      we_q  <= we_n_i;
      if (ras_rise) begin
        state_q <= CYC_IDLE;
      end else if (ras_fall) begin
        if (!cas_n_i) begin
          state_q <= CYC_REF;
          ref_q   <= ref_q + 1'b1;
        end else begin
          state_q <= CYC_ROW;
          row_q   <= addr_i[AR_W-1:0];
        end
      end else if (access_q) begin
        if (cas_fall) begin
          col_q     <= addr_i[AC_W-1:0];
          state_q   <= we_n_i ? CYC_READ : CYC_EWR;
          wr_seen_q <= ~we_n_i;
        end else if (cas_rise) begin
          state_q   <= CYC_ROW;
          wr_seen_q <= 1'b0;
        end else if (!cas_n_i && we_fall && state_q == CYC_READ) begin
          state_q   <= CYC_LWR;
          wr_seen_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dram_sd_lane.sv
module dram_sd_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strb_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic              access_i,
  input  logic              rd_load_i,
  input  logic              wr_seen_i,
  input  logic [LANE_W-1:0] rd_byte_i,
  output logic              wr_o,
  output logic              drv_o,
  output logic [LANE_W-1:0] dq_o
);
  logic              strb_q, oe_q, valid_q, wr_act_q, wr_act;
  logic [LANE_W-1:0] data_q;

  // byte write fires on the later of lane strobe fall and write enable fall
  assign wr_act = access_i & ~strb_n_i & ~we_n_i;
  assign wr_o   = wr_act & ~wr_act_q;
  assign drv_o  = valid_q & ~strb_q & ~oe_q & ~wr_seen_i;
  assign dq_o   = drv_o ? data_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q   <= 1'b1;
      oe_q     <= 1'b1;
      valid_q  <= 1'b0;
      wr_act_q <= 1'b0;
      data_q   <= '0;
    end else begin
      strb_q   <= strb_n_i;
      oe_q     <= oe_n_i;
      wr_act_q <= wr_act;
      if (rd_load_i) begin
        valid_q <= 1'b1;
        data_q  <= rd_byte_i;
      end else if (!strb_q && strb_n_i) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dram_sd_array.sv
module dram_sd_array #(
  parameter int IDX_W  = 6,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        wr_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;
  logic [LANES*LANE_W-1:0] mem_q [DEPTH];

  assign rdata_o = mem_q[idx_i];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (wr_i[l]) mem_q[idx_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/dram_strobe_dec.sv
module dram_strobe_dec
  import dram_sd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 8,
  parameter int AR_W   = 3,
  parameter int AC_W   = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ras_n_i,
  input  logic                    casl_n_i,
  input  logic                    cash_n_i,
  input  logic                    we_n_i,
  input  logic                    oe_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic [LANES-1:0]        dq_oe_o,
  output logic [2:0]              cyc_o,
  output logic [ADDR_W-1:0]       ref_row_o
);
  localparam int IDX_W = AR_W + AC_W;
  localparam int DQ_W  = LANES * LANE_W;

  cyc_e            cyc;
  logic [AR_W-1:0] row;
  logic [AC_W-1:0] col;
  logic            access, rd_load, wr_seen;
  logic [LANES-1:0] strb_n, wr;
  logic [DQ_W-1:0] rdata;

  assign strb_n = {cash_n_i, casl_n_i};
  assign cyc_o  = cyc;

  dram_sd_fsm #(.ADDR_W(ADDR_W), .AR_W(AR_W), .AC_W(AC_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ras_n_i  (ras_n_i),
    .cas_n_i  (casl_n_i & cash_n_i),
    .we_n_i   (we_n_i),
    .addr_i   (addr_i),
    .cyc_o    (cyc),
    .row_o    (row),
    .col_o    (col),
    .access_o (access),
    .rd_load_o(rd_load),
    .wr_seen_o(wr_seen),
    .ref_row_o(ref_row_o)
  );

  dram_sd_array #(.IDX_W(IDX_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk_i  (clk_i),
    .wr_i   (wr),
    .idx_i  ({row, col}),
    .wdata_i(dq_i),
    .rdata_o(rdata)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dram_sd_lane #(.LANE_W(LANE_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strb_n_i (strb_n[l]),
      .we_n_i   (we_n_i),
      .oe_n_i   (oe_n_i),
      .access_i (access),
      .rd_load_i(rd_load),
      .wr_seen_i(wr_seen),
      .rd_byte_i(rdata[l*LANE_W +: LANE_W]),
      .wr_o     (wr[l]),
      .drv_o    (dq_oe_o[l]),
      .dq_o     (dq_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/dram_strobe_dec_chk.sv
module dram_strobe_dec_chk
  import dram_sd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ras_n_i,
  input logic              casl_n_i,
  input logic              cash_n_i,
  input logic              oe_n_i,
  input logic [1:0]        dq_oe_o,
  input logic [2:0]        cyc_o,
  input logic [ADDR_W-1:0] ref_row_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R2
  ras_high_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(ras_n_i)) |-> (cyc_o == CYC_IDLE));

  // R3
  col_cycle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && (cyc_o == CYC_READ || cyc_o == CYC_EWR || cyc_o == CYC_LWR))
      |-> !($past(casl_n_i) && $past(cash_n_i)));

  // R5
  early_wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o == CYC_EWR) |-> (dq_oe_o == 2'b00));

  // R6
  late_wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o == CYC_LWR) |-> (dq_oe_o == 2'b00));

  // R8
  ref_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && cyc_o == CYC_REF && $past(cyc_o) != CYC_REF)
      |-> (ref_row_o == $past(ref_row_o) + 1'b1));

  // R8
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !(cyc_o == CYC_REF && $past(cyc_o) != CYC_REF)) |-> $stable(ref_row_o));

  // R9
  lane_lo_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ($past(casl_n_i) || $past(oe_n_i))) |-> !dq_oe_o[0]);

  // R9
  lane_hi_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ($past(cash_n_i) || $past(oe_n_i))) |-> !dq_oe_o[1]);
endmodule

bind dram_strobe_dec dram_strobe_dec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ras_n_i  (ras_n_i),
  .casl_n_i (casl_n_i),
  .cash_n_i (cash_n_i),
  .oe_n_i   (oe_n_i),
  .dq_oe_o  (dq_oe_o),
  .cyc_o    (cyc_o),
  .ref_row_o(ref_row_o)
);

// File: tb/dram_strobe_dec_tb_top.sv
module dram_strobe_dec_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 36;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ras_n_i = 1'b1, casl_n_i = 1'b1, cash_n_i = 1'b1, we_n_i = 1'b1, oe_n_i = 1'b1;
  logic [11:0] addr_i = '0;
  logic [15:0] dq_i = '0;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe_o;
  logic [2:0]  cyc_o;
  logic [11:0] ref_row_o;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dram_strobe_dec dut_i (
    .clk_i, .rst_ni, .ras_n_i, .casl_n_i, .cash_n_i, .we_n_i, .oe_n_i,
    .addr_i, .dq_i, .dq_o, .dq_oe_o, .cyc_o, .ref_row_o
  );

  typedef struct packed {
    logic [4:0]  pins;   // ras, casl, cash, we, oe (active low)
    logic [11:0] addr;
    logic [15:0] din;
    logic [2:0]  cyc;
    logic [1:0]  oe;
    logic [15:0] dq;
    logic [11:0] rref;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{5'b11111, 12'h000, 16'h0000, 3'd0, 2'b00, 16'h0000, 12'd0, 4'd2},  // R2 idle
    '{5'b01111, 12'h002, 16'h0000, 3'd1, 2'b00, 16'h0000, 12'd0, 4'd2},  // R2 open row 2
    '{5'b00001, 12'h001, 16'hA55A, 3'd3, 2'b00, 16'h0000, 12'd0, 4'd5},  // R5 early write col1
    '{5'b01111, 12'h001, 16'hA55A, 3'd1, 2'b00, 16'h0000, 12'd0, 4'd3},  // R3 end column cycle
    '{5'b00001, 12'h002, 16'hFFFF, 3'd3, 2'b00, 16'h0000, 12'd0, 4'd5},  // R5 col2 full word
    '{5'b01111, 12'h002, 16'hFFFF, 3'd1, 2'b00, 16'h0000, 12'd0, 4'd3},
    '{5'b00101, 12'h002, 16'h1234, 3'd3, 2'b00, 16'h0000, 12'd0, 4'd7},  // R7 low byte only
    '{5'b01111, 12'h002, 16'h0000, 3'd1, 2'b00, 16'h0000, 12'd0, 4'd3},
    '{5'b00010, 12'h001, 16'h0000, 3'd2, 2'b11, 16'hA55A, 12'd0, 4'd4},  // R4 word read
    '{5'b00011, 12'h001, 16'h0000, 3'd2, 2'b00, 16'h0000, 12'd0, 4'd9},  // R9 oe high
    '{5'b00010, 12'h001, 16'h0000, 3'd2, 2'b11, 16'hA55A, 12'd0, 4'd9},  // R9 re-drive
    '{5'b00110, 12'h001, 16'h0000, 3'd2, 2'b01, 16'h005A, 12'd0, 4'd9},  // R9 high lane off
    '{5'b01110, 12'h001, 16'h0000, 3'd1, 2'b00, 16'h0000, 12'd0, 4'd3},  // R3 both high
    '{5'b01010, 12'h002, 16'h0000, 3'd2, 2'b10, 16'hFF00, 12'd0, 4'd4},  // R4 high lane first
    '{5'b00010, 12'h005, 16'h0000, 3'd2, 2'b11, 16'hFF34, 12'd0, 4'd3},  // R3 col from first fall, R7
    '{5'b01110, 12'h005, 16'h0000, 3'd1, 2'b00, 16'h0000, 12'd0, 4'd3},
    '{5'b00011, 12'h003, 16'h0000, 3'd2, 2'b00, 16'h0000, 12'd0, 4'd9},  // R9 read, oe high
    '{5'b00001, 12'h003, 16'hC3C3, 3'd4, 2'b00, 16'h0000, 12'd0, 4'd6},  // R6 late write
    '{5'b00000, 12'h003, 16'hC3C3, 3'd4, 2'b00, 16'h0000, 12'd0, 4'd6},  // R6 stays off
    '{5'b01111, 12'h003, 16'h0000, 3'd1, 2'b00, 16'h0000, 12'd0, 4'd3},
    '{5'b00010, 12'h003, 16'h0000, 3'd2, 2'b11, 16'hC3C3, 12'd0, 4'd6},  // R6 data stored
    '{5'b10010, 12'h003, 16'h0000, 3'd0, 2'b11, 16'hC3C3, 12'd0, 4'd10}, // R10 ras high, held
    '{5'b00010, 12'h003, 16'h0000, 3'd5, 2'b11, 16'hC3C3, 12'd1, 4'd10}, // R10 hidden refresh, R8
    '{5'b10010, 12'h003, 16'h0000, 3'd0, 2'b11, 16'hC3C3, 12'd1, 4'd10},
    '{5'b11110, 12'h003, 16'h0000, 3'd0, 2'b00, 16'h0000, 12'd1, 4'd10}, // R10 released
    '{5'b10011, 12'h003, 16'h0000, 3'd0, 2'b00, 16'h0000, 12'd1, 4'd8},
    '{5'b00011, 12'h003, 16'h0000, 3'd5, 2'b00, 16'h0000, 12'd2, 4'd8},  // R8 strobe-first refresh
    '{5'b10011, 12'h003, 16'h0000, 3'd0, 2'b00, 16'h0000, 12'd2, 4'd2},
    '{5'b11111, 12'h003, 16'h0000, 3'd0, 2'b00, 16'h0000, 12'd2, 4'd8},
    '{5'b01111, 12'h003, 16'h0000, 3'd1, 2'b00, 16'h0000, 12'd2, 4'd2},  // R2 open row 3
    '{5'b00001, 12'h001, 16'h0F0F, 3'd3, 2'b00, 16'h0000, 12'd2, 4'd5},
    '{5'b01111, 12'h001, 16'h0000, 3'd1, 2'b00, 16'h0000, 12'd2, 4'd3},
    '{5'b11111, 12'h001, 16'h0000, 3'd0, 2'b00, 16'h0000, 12'd2, 4'd2},
    '{5'b01110, 12'h002, 16'h0000, 3'd1, 2'b00, 16'h0000, 12'd2, 4'd2},
    '{5'b00010, 12'h001, 16'h0000, 3'd2, 2'b11, 16'hA55A, 12'd2, 4'd2},  // R2 row 2 kept apart
    '{5'b11111, 12'h000, 16'h0000, 3'd0, 2'b00, 16'h0000, 12'd2, 4'd2}
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_pins(input logic [4:0] p);
    {ras_n_i, casl_n_i, cash_n_i, we_n_i, oe_n_i} = p;
  endtask

  task automatic cbr();
    set_pins(5'b10011); step();
    set_pins(5'b00011); step();
    set_pins(5'b10011); step();
    set_pins(5'b11111); step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #(CLK_PERIOD * 2);
    // R1 values while held in reset
    chk(1, "cyc in reset", 32'(cyc_o), 32'd0);
    chk(1, "oe in reset", 32'(dq_oe_o), 32'd0);
    chk(1, "ref in reset", 32'(ref_row_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    chk(1, "cyc after reset", 32'(cyc_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      set_pins(VEC[i].pins);
      addr_i = VEC[i].addr;
      dq_i   = VEC[i].din;
      step();
      chk(int'(VEC[i].req), $sformatf("vec %0d cyc", i), 32'(cyc_o), 32'(VEC[i].cyc));
      chk(int'(VEC[i].req), $sformatf("vec %0d oe", i), 32'(dq_oe_o), 32'(VEC[i].oe));
      chk(int'(VEC[i].req), $sformatf("vec %0d dq", i), 32'(dq_o), 32'(VEC[i].dq));
      chk(int'(VEC[i].req), $sformatf("vec %0d ref", i), 32'(ref_row_o), 32'(VEC[i].rref));
    end

    // R8 counter wrap: from 2 up to 4095, then to 0 and 1
    addr_i = 12'h003;
    for (int k = 0; k < 4093; k++) cbr();
    chk(8, "ref at top", 32'(ref_row_o), 32'd4095);
    cbr();
    chk(8, "ref wraps", 32'(ref_row_o), 32'd0);
    cbr();
    chk(8, "ref after wrap", 32'(ref_row_o), 32'd1);

    // R8 refresh left the array unchanged
    addr_i = 12'h002; set_pins(5'b01110); step();
    addr_i = 12'h001; set_pins(5'b00010); step();
    chk(8, "array kept", 32'(dq_o), 32'h0000A55A);
    chk(4, "read lanes", 32'(dq_oe_o), 32'd3);

    // R1 reset in the middle of a read
    @(posedge clk_i); #1;
    rst_ni = 1'b0; #1;
    chk(1, "oe after mid reset", 32'(dq_oe_o), 32'd0);
    chk(1, "cyc after mid reset", 32'(cyc_o), 32'd0);
    chk(1, "ref after mid reset", 32'(ref_row_o), 32'd0);
    @(negedge clk_i);
    set_pins(5'b11111);
    rst_ni = 1'b1;
    step();
    chk(1, "idle after release", 32'(cyc_o), 32'd0);
    summary();
  end
endmodule